// File: doc/BRIEF.md
# Blocked Int8 Matrix Multiply Engine

The engine multiplies two 64x64 matrices of signed 8-bit values and produces a 64x64 result. It works one output tile at a time. Each tile is 4 rows by 8 columns. One compute step takes a 4x16 slice of the left operand and a 16x8 slice of the right operand, multiplies them and adds the result into 32 accumulators. Four steps along the shared dimension complete a tile. The tile is then written to the output memory in a single wide write.

Both operands sit in local memories that are already tiled, each 256 bits wide. Each memory gives back one word per access, one cycle after the read enable. The result is built one block row at a time. For each tile column of the right operand, the engine fetches the same row of left-operand tiles again. A single start pulse runs the whole product. A one-cycle done pulse marks the final write.

Top module: `mm_blk_engine`

## Requirements
- R1: While reset is applied and after it is released, a_re_o, b_re_o, c_we_o and done_o are all low until a start pulse arrives.
- R2: Left tile (row block i, depth block k) takes words (i*4+k)*2 and (i*4+k)*2+1. Element (r,c) of the tile, with r in 0..3 and c in 0..15, is at bit (r*16+c)*8 of {word1,word0}. Read data is taken one cycle after a_re_o.
- R3: Right tile (depth block k, column block j) takes words (j*4+k)*4 through (j*4+k)*4+3. Element (k',n) of the tile, with k' in 0..15 and n in 0..7, is at bit (k'*8+n)*8 of {word3,word2,word1,word0}. Read data is taken one cycle after b_re_o.
- R4: Every output element is the exact two's-complement sum of its 64 signed products, given as a signed 32-bit value. The extremes are +1048576 for all -128 operands and -1040384 for 127 times -128.
- R5: Output tile (i,j) is written exactly once per run, to address i*8+j. Element (r,n) is at bits (r*8+n)*32 of c_wdata_o. A run makes 128 writes.
- R6: Tiles are written in block-row order. The first address is 0 and each later write goes to the previous address plus one.
- R7: In one run, each left-operand word is read exactly 8 times, once per tile column. Each right-operand word is read exactly 16 times, once per block row.
- R8: done_o is high for exactly one cycle. That cycle directly follows the final write.
- R9: A start pulse that arrives while a run is in progress has no effect. The run still makes exactly 128 writes and one done pulse.
- R10: A new run started after done clears the accumulators at its first step. Its results do not depend on the run before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one full product |
| a_re_o | output | 1 | Left-operand memory read enable |
| a_addr_o | output | 7 | Left-operand word address |
| a_rdata_i | input | 256 | Left-operand read data, one cycle after enable |
| b_re_o | output | 1 | Right-operand memory read enable |
| b_addr_o | output | 7 | Right-operand word address |
| b_rdata_i | input | 256 | Right-operand read data, one cycle after enable |
| c_we_o | output | 1 | Output tile write enable |
| c_addr_o | output | 7 | Output tile address |
| c_wdata_o | output | 1024 | 32 signed 32-bit results of one 4x8 tile |
| done_o | output | 1 | One-cycle pulse after the final tile write |

## Verification
Some properties are checked on every cycle. Each accumulator stays inside the 64-term bound. A write always follows a compute step. Successive writes go to consecutive addresses. Done comes only right after a write and lasts one cycle. No operand capture is still pending when a step computes. The numeric content cannot be shown by these properties: the tile layouts, the reuse counts, the ignored restart and the clearing between runs. Only the bench's full-matrix runs show them, using saturating, mixed-sign, hashed and identity operands, with every element compared against sums computed in the bench.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LAST,
    ST_MAC,
    ST_WRITE
  } mm_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mm_sequencer.sv
module mm_sequencer #(
  parameter int NBI     = 16,
  parameter int NBJ     = 8,
  parameter int KSTEPS  = 4,
  parameter int FETCH_N = 4,
  parameter int BI_W    = 4,
  parameter int BJ_W    = 3,
  parameter int BK_W    = 2,
  parameter int WD_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            fetch_o,
  output logic [WD_W-1:0] word_o,
  output logic [BI_W-1:0] bi_o,
  output logic [BJ_W-1:0] bj_o,
  output logic [BK_W-1:0] bk_o,
  output logic            mac_o,
  output logic            clear_o,
  output logic            wr_o,
  output logic            done_o
);
  import mm_pkg::*;

  mm_state_e       st_q, st_d;
  logic [WD_W-1:0] word_q, word_d;
  logic [BI_W-1:0] bi_q, bi_d;
  logic [BJ_W-1:0] bj_q, bj_d;
  logic [BK_W-1:0] bk_q, bk_d;
  logic            done_q, done_d;
  logic            last_tile;

  assign last_tile = (bi_q == BI_W'(NBI - 1)) && (bj_q == BJ_W'(NBJ - 1));

  always_comb begin
    st_d   = st_q;
    word_d = word_q;
    bi_d   = bi_q;
    bj_d   = bj_q;
    bk_d   = bk_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_FETCH;
          word_d = '0;
          bi_d   = '0;
          bj_d   = '0;
          bk_d   = '0;
        end
      end
      ST_FETCH: begin
        if (word_q == WD_W'(FETCH_N - 1)) st_d = ST_LAST;
        else word_d = word_q + 1'b1;
      end
      ST_LAST: st_d = ST_MAC;
      ST_MAC: begin
        word_d = '0;
        if (bk_q == BK_W'(KSTEPS - 1)) begin
          st_d = ST_WRITE;
        end else begin
          bk_d = bk_q + 1'b1;
          st_d = ST_FETCH;
        end
      end
      ST_WRITE: begin
        bk_d = '0;
        if (last_tile) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_FETCH;
          if (bj_q == BJ_W'(NBJ - 1)) begin
            bj_d = '0;
            bi_d = bi_q + 1'b1;
          end else begin
            bj_d = bj_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      word_q <= '0;
      bi_q   <= '0;
      bj_q   <= '0;
      bk_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      word_q <= word_d;
      bi_q   <= bi_d;
      bj_q   <= bj_d;
      bk_q   <= bk_d;
      done_q <= done_d;
    end
  end

  assign fetch_o = (st_q == ST_FETCH);
  assign mac_o   = (st_q == ST_MAC);
  assign clear_o = (bk_q == '0);
  assign wr_o    = (st_q == ST_WRITE);
  assign word_o  = word_q;
  assign bi_o    = bi_q;
  assign bj_o    = bj_q;
  assign bk_o    = bk_q;
  assign done_o  = done_q;

  // R5: a write is always preceded by the final depth step
  a_r5_write_after_mac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(mac_o) && (bk_q == BK_W'(KSTEPS - 1)));

  // R9: an accepted start leaves idle; a busy run never returns to idle on start
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH) && start_i |=> (st_q != ST_IDLE));
endmodule

// File: rtl/mm_tile_loader.sv
module mm_tile_loader #(
  parameter int MW      = 256,
  parameter int KSTEPS  = 4,
  parameter int A_WORDS = 2,
  parameter int B_WORDS = 4,
  parameter int A_AW    = 7,
  parameter int B_AW    = 7,
  parameter int BI_W    = 4,
  parameter int BJ_W    = 3,
  parameter int BK_W    = 2,
  parameter int WD_W    = 2,
  localparam int A_BITS = A_WORDS * MW,
  localparam int B_BITS = B_WORDS * MW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              mac_i,
  input  logic [WD_W-1:0]   word_i,
  input  logic [BI_W-1:0]   bi_i,
  input  logic [BJ_W-1:0]   bj_i,
  input  logic [BK_W-1:0]   bk_i,
  output logic              a_re_o,
  output logic [A_AW-1:0]   a_addr_o,
  input  logic [MW-1:0]     a_rdata_i,
  output logic              b_re_o,
  output logic [B_AW-1:0]   b_addr_o,
  input  logic [MW-1:0]     b_rdata_i,
  output logic [A_BITS-1:0] a_tile_o,
  output logic [B_BITS-1:0] b_tile_o
);
  logic              a_vld_q, b_vld_q;
  logic [WD_W-1:0]   word_q;
  logic [A_BITS-1:0] a_tile_q;
  logic [B_BITS-1:0] b_tile_q;

  // left tiles: row-block major, right tiles: column-block major
  assign a_re_o   = fetch_i && (int'(word_i) < A_WORDS);
  assign b_re_o   = fetch_i && (int'(word_i) < B_WORDS);
  assign a_addr_o = A_AW'((int'(bi_i) * KSTEPS + int'(bk_i)) * A_WORDS + int'(word_i));
  assign b_addr_o = B_AW'((int'(bj_i) * KSTEPS + int'(bk_i)) * B_WORDS + int'(word_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q  <= 1'b0;
      b_vld_q  <= 1'b0;
      word_q   <= '0;
      a_tile_q <= '0;
      b_tile_q <= '0;
    end else begin
      a_vld_q <= a_re_o;
      b_vld_q <= b_re_o;
      word_q  <= word_i;
      if (a_vld_q) a_tile_q[int'(word_q) * MW +: MW] <= a_rdata_i;
      if (b_vld_q) b_tile_q[int'(word_q) * MW +: MW] <= b_rdata_i;
    end
  end

  assign a_tile_o = a_tile_q;
  assign b_tile_o = b_tile_q;

  // R2/R3: every word of both tiles has landed before the step computes
  a_r2_no_capture_in_mac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_i |-> !a_vld_q && !b_vld_q);

  a_r3_b_read_fetch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_re_o |=> !mac_i);
endmodule

// File: rtl/mm_mac_array.sv
module mm_mac_array #(
  parameter int DIM   = 64,
  parameter int TM    = 4,
  parameter int TK    = 16,
  parameter int TN    = 8,
  parameter int DW    = 8,
  parameter int ACC_W = 32,
  localparam int A_BITS = TM * TK * DW,
  localparam int B_BITS = TK * TN * DW,
  localparam int C_BITS = TM * TN * ACC_W,
  localparam int PW     = 2 * DW,
  localparam int SUM_W  = PW + $clog2(TK) + 1,
  localparam int MAX_MAG = DIM * (2 ** (2 * DW - 2))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [A_BITS-1:0] a_tile_i,
  input  logic [B_BITS-1:0] b_tile_i,
  input  logic              mac_i,
  input  logic              clear_i,
  output logic [C_BITS-1:0] acc_o
);
  for (genvar r = 0; r < TM; r++) begin : g_row
    for (genvar n = 0; n < TN; n++) begin : g_col
      logic signed [SUM_W-1:0] sum;
      logic signed [ACC_W-1:0] acc_q;

      always_comb begin
        logic signed [PW-1:0] prod;
        sum = '0;
        for (int k = 0; k < TK; k++) begin
          prod = $signed(a_tile_i[(r * TK + k) * DW +: DW]) *
                 $signed(b_tile_i[(k * TN + n) * DW +: DW]);
          sum  = sum + SUM_W'(prod);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else if (mac_i) acc_q <= clear_i ? ACC_W'(sum) : acc_q + ACC_W'(sum);
      end

      assign acc_o[(r * TN + n) * ACC_W +: ACC_W] = acc_q;

      // R4: no partial or final sum leaves the 64-term int8 range
      a_r4_acc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_q <= MAX_MAG) && (acc_q >= -MAX_MAG));
    end
  end
endmodule

// File: rtl/mm_blk_engine.sv
module mm_blk_engine #(
  parameter int DIM   = 64,
  parameter int TM    = 4,
  parameter int TK    = 16,
  parameter int TN    = 8,
  parameter int DW    = 8,
  parameter int ACC_W = 32,
  parameter int MW    = 256,
  localparam int KSTEPS  = DIM / TK,
  localparam int NBI     = DIM / TM,
  localparam int NBJ     = DIM / TN,
  localparam int A_WORDS = (TM * TK * DW) / MW,
  localparam int B_WORDS = (TK * TN * DW) / MW,
  localparam int FETCH_N = mm_pkg::max2(A_WORDS, B_WORDS),
  localparam int A_DEPTH = NBI * KSTEPS * A_WORDS,
  localparam int B_DEPTH = NBJ * KSTEPS * B_WORDS,
  localparam int C_DEPTH = NBI * NBJ,
  localparam int A_AW    = (A_DEPTH > 1) ? $clog2(A_DEPTH) : 1,
  localparam int B_AW    = (B_DEPTH > 1) ? $clog2(B_DEPTH) : 1,
  localparam int C_AW    = (C_DEPTH > 1) ? $clog2(C_DEPTH) : 1,
  localparam int C_BITS  = TM * TN * ACC_W,
  localparam int BI_W    = (NBI > 1) ? $clog2(NBI) : 1,
  localparam int BJ_W    = (NBJ > 1) ? $clog2(NBJ) : 1,
  localparam int BK_W    = (KSTEPS > 1) ? $clog2(KSTEPS) : 1,
  localparam int WD_W    = (FETCH_N > 1) ? $clog2(FETCH_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              a_re_o,
  output logic [A_AW-1:0]   a_addr_o,
  input  logic [MW-1:0]     a_rdata_i,
  output logic              b_re_o,
  output logic [B_AW-1:0]   b_addr_o,
  input  logic [MW-1:0]     b_rdata_i,
  output logic              c_we_o,
  output logic [C_AW-1:0]   c_addr_o,
  output logic [C_BITS-1:0] c_wdata_o,
  output logic              done_o
);
  logic            fetch, mac, clear, wr, done;
  logic [WD_W-1:0] word;
  logic [BI_W-1:0] bi;
  logic [BJ_W-1:0] bj;
  logic [BK_W-1:0] bk;
  logic [TM*TK*DW-1:0] a_tile;
  logic [TK*TN*DW-1:0] b_tile;

  mm_sequencer #(
    .NBI(NBI), .NBJ(NBJ), .KSTEPS(KSTEPS), .FETCH_N(FETCH_N),
    .BI_W(BI_W), .BJ_W(BJ_W), .BK_W(BK_W), .WD_W(WD_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .fetch_o(fetch), .word_o(word), .bi_o(bi), .bj_o(bj), .bk_o(bk),
    .mac_o(mac), .clear_o(clear), .wr_o(wr), .done_o(done)
  );

  mm_tile_loader #(
    .MW(MW), .KSTEPS(KSTEPS), .A_WORDS(A_WORDS), .B_WORDS(B_WORDS),
    .A_AW(A_AW), .B_AW(B_AW), .BI_W(BI_W), .BJ_W(BJ_W), .BK_W(BK_W), .WD_W(WD_W)
  ) u_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_i(fetch), .mac_i(mac), .word_i(word),
    .bi_i(bi), .bj_i(bj), .bk_i(bk),
    .a_re_o(a_re_o), .a_addr_o(a_addr_o), .a_rdata_i(a_rdata_i),
    .b_re_o(b_re_o), .b_addr_o(b_addr_o), .b_rdata_i(b_rdata_i),
    .a_tile_o(a_tile), .b_tile_o(b_tile)
  );

  mm_mac_array #(
    .DIM(DIM), .TM(TM), .TK(TK), .TN(TN), .DW(DW), .ACC_W(ACC_W)
  ) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_tile_i(a_tile), .b_tile_i(b_tile),
    .mac_i(mac), .clear_i(clear), .acc_o(c_wdata_o)
  );

  assign c_we_o   = wr;
  assign c_addr_o = C_AW'(int'(bi) * NBJ + int'(bj));
  assign done_o   = done;

  // write-order tracking for the ordering property
  logic            seen_q;
  logic [C_AW-1:0] prev_addr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      prev_addr_q <= '0;
    end else if (done_o) begin
      seen_q <= 1'b0;
    end else if (c_we_o) begin
      seen_q      <= 1'b1;
      prev_addr_q <= c_addr_o;
    end
  end

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we_o && seen_q |-> (c_addr_o == prev_addr_q + 1'b1));

  a_r6_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we_o && !seen_q |-> (c_addr_o == '0));

  a_r8_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(c_we_o) && ($past(c_addr_o) == C_AW'(C_DEPTH - 1)));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/mm_blk_engine_tb_top.sv
`timescale 1ns/1ps
module mm_blk_engine_tb_top;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic a_re, b_re, c_we, done;
  logic [6:0] a_addr, b_addr, c_addr;
  logic [255:0] a_rdata, b_rdata;
  logic [1023:0] c_wdata;

  always #2 clk = ~clk;

  mm_blk_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_re_o(a_re), .a_addr_o(a_addr), .a_rdata_i(a_rdata),
    .b_re_o(b_re), .b_addr_o(b_addr), .b_rdata_i(b_rdata),
    .c_we_o(c_we), .c_addr_o(c_addr), .c_wdata_o(c_wdata),
    .done_o(done)
  );

  logic [255:0]  a_mem [128];
  logic [255:0]  b_mem [128];
  logic [1023:0] c_got [128];
  int a_cnt [128];
  int b_cnt [128];
  int c_cnt [128];
  int c_exp [N][N];
  int tests = 0, fails = 0;
  int cyc = 0, we_total = 0, last_we_cyc = 0, done_cyc = 0, done_n = 0, order_err = 0;
  int last_addr = 0;

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (a_re) begin a_rdata <= a_mem[a_addr]; a_cnt[a_addr] <= a_cnt[a_addr] + 1; end
    if (b_re) begin b_rdata <= b_mem[b_addr]; b_cnt[b_addr] <= b_cnt[b_addr] + 1; end
  end

  always @(negedge clk) begin
    if (rst_n && c_we) begin
      if (we_total == 0 && c_addr != 0) order_err++;
      if (we_total > 0 && int'(c_addr) != last_addr + 1) order_err++;
      last_addr = int'(c_addr);
      c_got[c_addr] = c_wdata;
      c_cnt[c_addr]++;
      we_total++;
      last_we_cyc = cyc;
    end
    if (rst_n && done) begin
      done_n++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ea(input int p, input int i, input int j);
    case (p)
      0: return -128;
      1: return 127;
      2: return ((i * 29 + j * 53 + 7) % 256) - 128;
      default: return ((i * 13 + j * 7) % 256) - 128;
    endcase
  endfunction

  function automatic int eb(input int p, input int i, input int j);
    case (p)
      0, 1: return -128;
      2: return ((i * 41 + j * 17 + 3) % 256) - 128;
      default: return (i == j) ? 1 : 0;
    endcase
  endfunction

  task automatic load(input int p);
    logic [511:0]  av;
    logic [1023:0] bv;
    for (int bi = 0; bi < 16; bi++)
      for (int bk = 0; bk < 4; bk++) begin
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 16; c++)
            av[(r * 16 + c) * 8 +: 8] = 8'(ea(p, bi * 4 + r, bk * 16 + c));
        for (int w = 0; w < 2; w++) a_mem[(bi * 4 + bk) * 2 + w] = av[w * 256 +: 256];
      end
    for (int bj = 0; bj < 8; bj++)
      for (int bk = 0; bk < 4; bk++) begin
        for (int k = 0; k < 16; k++)
          for (int n = 0; n < 8; n++)
            bv[(k * 8 + n) * 8 +: 8] = 8'(eb(p, bk * 16 + k, bj * 8 + n));
        for (int w = 0; w < 4; w++) b_mem[(bj * 4 + bk) * 4 + w] = bv[w * 256 +: 256];
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int s = 0;
        for (int k = 0; k < N; k++) s += ea(p, i, k) * eb(p, k, j);
        c_exp[i][j] = s;
      end
  endtask

  task automatic run(input int p, input bit restart);
    int t_wait = 0;
    int tiles_ok = 0;
    load(p);
    for (int i = 0; i < 128; i++) begin a_cnt[i] = 0; b_cnt[i] = 0; c_cnt[i] = 0; end
    we_total = 0; done_n = 0; order_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (done_n == 0 && t_wait < 20000) begin
      @(negedge clk);
      t_wait++;
      if (restart && (t_wait == 700 || t_wait == 1901)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done_n > 0, "R8", "run finished", t_wait, 3200);
    repeat (5) @(negedge clk);
    chk(done_n == 1, "R8", "done pulses", done_n, 1);
    chk(done_cyc == last_we_cyc + 1, "R8", "done cycle after last write", done_cyc, last_we_cyc + 1);
    chk(we_total == 128, restart ? "R9" : "R5", "write count", we_total, 128);
    chk(order_err == 0, "R6", "block-row order errors", order_err, 0);
    begin
      int bad = -1;
      for (int i = 0; i < 128; i++) if (c_cnt[i] != 1 && bad < 0) bad = i;
      chk(bad < 0, "R5", "tile written once (first bad addr)", bad, -1);
    end
    begin
      int bad_a = 0, bad_b = 0;
      for (int i = 0; i < 128; i++) begin
        if (a_cnt[i] != 8) bad_a++;
        if (b_cnt[i] != 16) bad_b++;
      end
      chk(bad_a == 0, "R7", "left words not read 8 times", bad_a, 0);
      chk(bad_b == 0, "R7", "right words not read 16 times", bad_b, 0);
    end
    for (int t = 0; t < 128; t++) begin
      int bi = t / 8, bj = t % 8;
      longint act = 0, exp = 0;
      bit ok = 1'b1;
      for (int r = 0; r < 4; r++)
        for (int n = 0; n < 8; n++) begin
          int g = $signed(c_got[t][(r * 8 + n) * 32 +: 32]);
          if (ok && g != c_exp[bi * 4 + r][bj * 8 + n]) begin
            ok = 1'b0; act = g; exp = c_exp[bi * 4 + r][bj * 8 + n];
          end
        end
      if (ok) tiles_ok++;
      chk(ok, "R4", $sformatf("pattern %0d tile %0d (R2 R3 layout)", p, t), act, exp);
    end
    if (p == 0) chk(c_exp[0][0] == 1048576 && c_got[0][31:0] == 32'd1048576,
                    "R4", "max positive", $signed(c_got[0][31:0]), 1048576);
    if (p == 1) begin
      chk($signed(c_got[127][1023:992]) == -1040384, "R4", "max negative",
          $signed(c_got[127][1023:992]), -1040384);
      chk(tiles_ok == 128, "R10", "fresh results after previous run", tiles_ok, 128);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    a_rdata = '0;
    b_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!a_re && !b_re && !c_we && !done, "R1", "outputs in reset",
        {a_re, b_re, c_we, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!a_re && !b_re && !c_we && !done, "R1", "idle after reset",
        {a_re, b_re, c_we, done}, 0);
    run(0, 1'b0);
    run(1, 1'b1);
    run(2, 1'b0);
    run(3, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule